// File: doc/BRIEF.md
# Parallel Camera Pixel Capture Unit

This block sits behind an 8-bit parallel CMOS image sensor port. It runs on the sensor's pixel clock. It samples the data bus together with a frame-sync qualifier and a line-sync qualifier, and pairs consecutive bytes into 16-bit RGB565 pixels. Each pixel is also delivered split into its red, green and blue fields. The block counts columns and rows, and it emits each finished pixel as a single-cycle strobe with its x/y position. A start-of-frame flag and an end-of-line flag travel with the pixel, so a frame buffer or display writer downstream can place it directly.

Capture starts only after the first complete frame-sync pulse seen after reset, so a frame already under way when reset is released is dropped. Pixels beyond the configured line width or frame height are not passed on. Every finished line is checked against the configured width, and every finished frame against the configured height. A mismatch sets a sticky error flag.

Top module: `cam_pixel_capture`

## Requirements
- R1: While reset is high and on the first cycle after it, `pix_valid`, `pix_sof`, `pix_eol`, `line_err` and `frame_err` are all low.
- R2: Bytes presented while `href` is low produce no pixel and do not disturb the pairing of later bytes.
- R3: Within a line the first byte of each pair is the high byte and the second is the low byte, so `pix_data = {first, second}`. The fields are `pix_red = pix_data[15:11]`, `pix_grn = pix_data[10:5]` and `pix_blu = pix_data[4:0]`. Two consecutive cycles never both carry a pixel.
- R4: Byte pairing restarts at every rising edge of `href`: a line that ends with an unpaired byte has that byte dropped, and the next line pairs correctly from its first byte.
- R5: `pix_x` counts pixels from 0 within each line. `pix_y` advances by one at each falling edge of `href` and returns to 0 while `vsync` is high.
- R6: `pix_sof` is high exactly with the pixel at (0,0). `pix_eol` is high exactly with the pixel at x = H_PIXELS-1.
- R7: No pixel is emitted before `vsync` has gone high and then low again after reset. Once capture is enabled it stays enabled.
- R8: Pixels with column index ≥ H_PIXELS or row index ≥ V_LINES are not emitted.
- R9: Once capture is enabled, `line_err` is set when a line ends with an odd byte count or with a pixel count other than H_PIXELS. It then stays high until reset.
- R10: Once capture is enabled, `frame_err` is set when `vsync` rises after a frame whose line count was not V_LINES. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Frame-sync qualifier; high between frames |
| href | input | 1 | Line-sync qualifier; high while active bytes are on the bus |
| cam_data | input | 8 | Sensor data bus |
| pix_valid | output | 1 | One-cycle strobe for a finished pixel |
| pix_data | output | 16 | RGB565 pixel word |
| pix_red | output | 5 | Red field |
| pix_grn | output | 6 | Green field |
| pix_blu | output | 5 | Blue field |
| pix_x | output | $clog2(H_PIXELS) | Column of the pixel |
| pix_y | output | $clog2(V_LINES) | Row of the pixel |
| pix_sof | output | 1 | Marks the pixel at (0,0) |
| pix_eol | output | 1 | Marks the last pixel of a line |
| line_err | output | 1 | Sticky line geometry error |
| frame_err | output | 1 | Sticky frame geometry error |

## Verification
The assertions assume that `href` only goes high while `vsync` is low, and that every line ends with `href` low for at least one cycle before the next frame-sync pulse. Without this, the row reset and the line checks could overlap. The stimulus always drops `href` for several idle cycles between lines and surrounds each `vsync` pulse with idle cycles. It puts changing garbage on the data bus during every blanking gap. The bench is built with a small geometry so that several full frames fit, including lines with an odd byte, lines that are too long and frames with an extra line.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef struct packed {
    logic [4:0] red;
    logic [5:0] grn;
    logic [4:0] blu;
  } rgb565_t;
endpackage

// File: rtl/cam_sync_track.sv
module cam_sync_track #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync_i,
  input  logic          href_i,
  input  logic [DW-1:0] data_i,
  output logic          vs_o,
  output logic          hr_o,
  output logic [DW-1:0] byte_o,
  output logic          hr_rise,
  output logic          hr_fall,
  output logic          vs_rise,
  output logic          armed
);
  logic vs_p, hr_p, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_o      <= 1'b1;
      vs_p      <= 1'b1;
      hr_o      <= 1'b0;
      hr_p      <= 1'b0;
      byte_o    <= '0;
      seen_rise <= 1'b0;
      armed     <= 1'b0;
    end else begin
      vs_o   <= vsync_i;
      vs_p   <= vs_o;
      hr_o   <= href_i;
      hr_p   <= hr_o;
      byte_o <= data_i;
      if (vs_o && !vs_p) seen_rise <= 1'b1;
      if (!vs_o && vs_p && seen_rise) armed <= 1'b1;
    end
  end

  assign hr_rise = hr_o & ~hr_p;
  assign hr_fall = ~hr_o & hr_p;
  assign vs_rise = vs_o & ~vs_p;

  p_armed_stays_r7: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
endmodule

// File: rtl/cam_byte_pair.sv
module cam_byte_pair #(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hr,
  input  logic          hr_rise,
  input  logic [DW-1:0] byte_i,
  output logic          pair_done,
  output logic [PW-1:0] pair_word,
  output logic          odd_tail
);
  logic          phase;
  logic [DW-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      hi_byte <= '0;
    end else if (hr) begin
      if (hr_rise || !phase) begin
        hi_byte <= byte_i;
        phase   <= 1'b1;
      end else begin
        phase   <= 1'b0;
      end
    end else begin
      phase <= 1'b0;
    end
  end

  assign pair_done = hr & phase & ~hr_rise;
  assign pair_word = {hi_byte, byte_i};
  assign odd_tail  = phase;

  p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
    pair_done |=> !pair_done);
endmodule

// File: rtl/cam_geom.sv
module cam_geom #(
  parameter int H_PIXELS = 320,
  parameter int V_LINES  = 240,
  localparam int CW = $clog2(H_PIXELS + 1),
  localparam int RW = $clog2(V_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs,
  input  logic          hr_rise,
  input  logic          hr_fall,
  input  logic          vs_rise,
  input  logic          armed,
  input  logic          pair_done,
  input  logic          odd_tail,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          in_range,
  output logic          line_err,
  output logic          frame_err
);
  localparam logic [CW-1:0] COL_END = CW'(H_PIXELS);
  localparam logic [RW-1:0] ROW_END = RW'(V_LINES);

  logic col_ovf, row_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      col_ovf <= 1'b0;
    end else if (hr_rise) begin
      col     <= '0;
      col_ovf <= 1'b0;
    end else if (pair_done) begin
      if (col < COL_END) col <= col + 1'b1;
      else               col_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || vs) begin
      row     <= '0;
      row_ovf <= 1'b0;
    end else if (hr_fall) begin
      if (row < ROW_END) row <= row + 1'b1;
      else               row_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_err  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (armed && hr_fall && (odd_tail || col_ovf || col != COL_END))
        line_err <= 1'b1;
      if (armed && vs_rise && (row_ovf || row != ROW_END))
        frame_err <= 1'b1;
    end
  end

  assign in_range = (col < COL_END) && (row < ROW_END);

  p_line_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    line_err |=> line_err);
  p_frame_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
  p_row_clear_r5: assert property (@(posedge clk) disable iff (rst)
    vs |=> row == '0);
endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture #(
  parameter int H_PIXELS = 320,
  parameter int V_LINES  = 240,
  parameter int DW       = 8,
  localparam int XW = $clog2(H_PIXELS),
  localparam int YW = $clog2(V_LINES),
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync,
  input  logic          href,
  input  logic [DW-1:0] cam_data,
  output logic          pix_valid,
  output logic [PW-1:0] pix_data,
  output logic [4:0]    pix_red,
  output logic [5:0]    pix_grn,
  output logic [4:0]    pix_blu,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          pix_sof,
  output logic          pix_eol,
  output logic          line_err,
  output logic          frame_err
);
  import cam_pkg::*;

  localparam int CW = $clog2(H_PIXELS + 1);
  localparam int RW = $clog2(V_LINES + 1);
  localparam logic [CW-1:0] LAST_COL = CW'(H_PIXELS - 1);

  logic          vs_s, hr_s, hr_rise, hr_fall, vs_rise, armed;
  logic [DW-1:0] byte_s;
  logic          pair_done, odd_tail, in_range;
  logic [PW-1:0] pair_word;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic          emit;
  rgb565_t       fields;

  cam_sync_track #(.DW(DW)) u_sync (
    .clk(clk), .rst(rst), .vsync_i(vsync), .href_i(href), .data_i(cam_data),
    .vs_o(vs_s), .hr_o(hr_s), .byte_o(byte_s), .hr_rise(hr_rise),
    .hr_fall(hr_fall), .vs_rise(vs_rise), .armed(armed)
  );

  cam_byte_pair #(.DW(DW)) u_pair (
    .clk(clk), .rst(rst), .hr(hr_s), .hr_rise(hr_rise), .byte_i(byte_s),
    .pair_done(pair_done), .pair_word(pair_word), .odd_tail(odd_tail)
  );

  cam_geom #(.H_PIXELS(H_PIXELS), .V_LINES(V_LINES)) u_geom (
    .clk(clk), .rst(rst), .vs(vs_s), .hr_rise(hr_rise), .hr_fall(hr_fall),
    .vs_rise(vs_rise), .armed(armed), .pair_done(pair_done),
    .odd_tail(odd_tail), .col(col), .row(row), .in_range(in_range),
    .line_err(line_err), .frame_err(frame_err)
  );

  assign emit   = pair_done & armed & in_range & ~vs_s;
  assign fields = rgb565_t'(pair_word[15:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_red   <= '0;
      pix_grn   <= '0;
      pix_blu   <= '0;
      pix_x     <= '0;
      pix_y     <= '0;
      pix_sof   <= 1'b0;
      pix_eol   <= 1'b0;
    end else begin
      pix_valid <= emit;
      pix_sof   <= emit && col == '0 && row == '0;
      pix_eol   <= emit && col == LAST_COL;
      if (emit) begin
        pix_data <= pair_word;
        pix_red  <= fields.red;
        pix_grn  <= fields.grn;
        pix_blu  <= fields.blu;
        pix_x    <= col[XW-1:0];
        pix_y    <= row[YW-1:0];
      end
    end
  end

  p_valid_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> armed);
  p_x_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (int'(pix_x) < H_PIXELS) && (int'(pix_y) < V_LINES));
  p_sof_at_origin_r6: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> pix_valid && pix_x == '0 && pix_y == '0);
  p_eol_at_last_r6: assert property (@(posedge clk) disable iff (rst)
    pix_eol |-> pix_valid && int'(pix_x) == H_PIXELS - 1);
endmodule

// File: tb/cam_pixel_capture_tb.sv
module cam_pixel_capture_tb;
  localparam int H  = 8;
  localparam int V  = 4;
  localparam int XW = $clog2(H);
  localparam int YW = $clog2(V);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync = 1'b0, href = 1'b0;
  logic [7:0] cam_data = 8'h00;
  logic pix_valid, pix_sof, pix_eol, line_err, frame_err;
  logic [15:0] pix_data;
  logic [4:0] pix_red, pix_blu;
  logic [5:0] pix_grn;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  always #5 clk = ~clk;

  cam_pixel_capture #(.H_PIXELS(H), .V_LINES(V)) u_dut (
    .clk(clk), .rst(rst), .vsync(vsync), .href(href), .cam_data(cam_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_red(pix_red),
    .pix_grn(pix_grn), .pix_blu(pix_blu), .pix_x(pix_x), .pix_y(pix_y),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .line_err(line_err),
    .frame_err(frame_err)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] exp_pix [0:255];
  int          exp_x   [0:255];
  int          exp_y   [0:255];
  bit          exp_sof [0:255];
  bit          exp_eol [0:255];
  int wr_i = 0;
  int rd_i = 0;
  logic [7:0] junk = 8'h5a;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every emitted pixel with the scoreboard
  always @(negedge clk) begin
    if (!rst && !done && pix_valid) begin
      if (rd_i >= wr_i) begin
        chk(1'b0, "R2 R7 R8 unexpected pixel", int'(pix_data), 0);
      end else begin
        chk(pix_data == exp_pix[rd_i], "R3 pixel word", int'(pix_data), int'(exp_pix[rd_i]));
        chk({pix_red, pix_grn, pix_blu} == exp_pix[rd_i], "R3 fields",
            int'({pix_red, pix_grn, pix_blu}), int'(exp_pix[rd_i]));
        chk(int'(pix_x) == exp_x[rd_i], "R5 x", int'(pix_x), exp_x[rd_i]);
        chk(int'(pix_y) == exp_y[rd_i], "R5 y", int'(pix_y), exp_y[rd_i]);
        chk(pix_sof == exp_sof[rd_i], "R6 sof", int'(pix_sof), int'(exp_sof[rd_i]));
        chk(pix_eol == exp_eol[rd_i], "R6 eol", int'(pix_eol), int'(exp_eol[rd_i]));
        rd_i++;
      end
    end
  end

  task automatic drive(input logic v, input logic h, input logic [7:0] d);
    @(negedge clk);
    vsync = v; href = h; cam_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      junk = junk * 8'd13 + 8'd7;
      drive(1'b0, 1'b0, junk);
    end
  endtask

  task automatic vs_pulse();
    idle(2);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 8'hc3);
    idle(3);
  endtask

  function automatic logic [15:0] pval(input int x, input int y, input int seed);
    return 16'(32'hA5C3 ^ (y * 32'h0911) ^ (x * 32'h0125) ^ seed);
  endfunction

  task automatic send_line(input int npix, input bit extra, input int y,
                           input bit emit, input int seed);
    logic [15:0] v;
    for (int x = 0; x < npix; x++) begin
      v = pval(x, y, seed);
      drive(1'b0, 1'b1, v[15:8]);
      drive(1'b0, 1'b1, v[7:0]);
      if (emit && x < H && y < V) begin
        exp_pix[wr_i] = v; exp_x[wr_i] = x; exp_y[wr_i] = y;
        exp_sof[wr_i] = (x == 0 && y == 0); exp_eol[wr_i] = (x == H - 1);
        wr_i++;
      end
    end
    if (extra) drive(1'b0, 1'b1, 8'hee);
    idle(4);
  endtask

  task automatic drain(input string tag);
    idle(4);
    chk(rd_i == wr_i, tag, rd_i, wr_i);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!pix_valid && !pix_sof && !pix_eol, "R1 outputs in reset", int'(pix_valid), 0);
    chk(!line_err && !frame_err, "R1 errors in reset", int'({line_err, frame_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pix_valid && !line_err && !frame_err, "R1 after release",
        int'({pix_valid, line_err, frame_err}), 0);
  endtask

  task automatic t_unarmed();
    send_line(H, 1'b0, 0, 1'b0, 1);
    send_line(H, 1'b1, 1, 1'b0, 2);
    drain("R7 no pixels before first vsync pulse");
    chk(!line_err, "R7 no line check before arming", int'(line_err), 0);
  endtask

  task automatic t_good_frame(input int seed);
    vs_pulse();
    for (int y = 0; y < V; y++) send_line(H, 1'b0, y, 1'b1, seed + y);
    drain("R5 R6 full frame pixel count");
    chk(!line_err, "R9 good lines leave line_err low", int'(line_err), 0);
  endtask

  task automatic t_frame_ok();
    vs_pulse();
    chk(!frame_err, "R10 good frame leaves frame_err low", int'(frame_err), 0);
  endtask

  task automatic t_odd_line();
    send_line(H, 1'b1, 0, 1'b1, 40);
    idle(2);
    chk(line_err, "R9 odd byte count sets line_err", int'(line_err), 1);
    for (int y = 1; y < V; y++) send_line(H, 1'b0, y, 1'b1, 50 + y);
    drain("R4 pairing restarts after odd line");
    chk(line_err, "R9 line_err stays set", int'(line_err), 1);
  endtask

  task automatic t_oversize();
    vs_pulse();
    chk(!frame_err, "R10 frame with odd line has right count", int'(frame_err), 0);
    for (int y = 0; y < V + 1; y++) send_line(H + 2, 1'b0, y, 1'b1, 70 + y);
    drain("R8 extra pixels and lines not emitted");
    vs_pulse();
    chk(frame_err, "R10 extra line sets frame_err", int'(frame_err), 1);
    idle(5);
    chk(frame_err, "R10 frame_err stays set", int'(frame_err), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unarmed();
    t_good_frame(100);
    t_frame_ok();
    for (int y = 0; y < V; y++) send_line(H, 1'b0, y, 1'b1, 200 + y);
    drain("R2 R3 second frame");
    vs_pulse();
    t_odd_line();
    t_oversize();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule